// File: doc/BRIEF.md
# Quad Load Line Merger

A load issued by a group of four threads carries one byte address per thread and a per-thread active flag. This block accepts such a quad load as a single request and compares the line portion of the addresses, which is everything above the 64-byte line offset. It then fetches each distinct line from the data-cache port exactly once. Lanes that point into the same line share one fetch, so a quad costs one cache access per unique line rather than one per thread.

Lines are fetched in lane order. In each cycle the lowest-numbered lane that still needs data chooses the line, and every other waiting lane in that line is covered by the same fetch. One cycle after a fetch is accepted, the cache returns the 512-bit line. For each lane covered by that line, the block extracts the 32-bit word the lane addressed. When all lanes have been served, it presents the four words together with a valid mask and an error mask, and pulses `done` for one cycle. A lane whose address is not word aligned is flagged in the error mask and is never fetched.

Top module: `quad_line_merger`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: For each quad, the number of accepted line requests equals the number of distinct line addresses (address bits [31:6]) among active, aligned lanes. No line request is made while `req_ready` is high.
- R3: The lines are requested in the order in which each line is first used, scanning lanes from 0 to 3.
- R4: For each active, aligned lane, `res_data[32*i +: 32]` holds the 32-bit word at word index address[5:2] of that lane's line, and `res_mask[i]` is 1.
- R5: An active lane with address[1:0] not equal to 0 sets `res_misalign[i]`, leaves `res_mask[i]` at 0 and its data word at 0, and causes no line request.
- R6: An inactive lane gives `res_mask[i]`=0, `res_misalign[i]`=0 and data 0, and causes no line request.
- R7: When the cache port is always ready, `done` is high in the cycle that follows the (N+1)-th rising clock edge after the accepting edge, where N is the R2 count.
- R8: `done` is high for exactly one cycle. `req_ready` is low from the accepting edge until after `done`, so only one quad is in flight at a time.
- R9: A line request that is not accepted stays asserted with an unchanged line address until the cache port accepts it.
- R10: A quad with no active lane finishes without any line request, with `done` high one cycle after acceptance and all masks zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Quad load offered |
| req_ready | output | 1 | Block idle, quad accepted when valid |
| req_addr | input | 128 | Byte address of lane i in bits [32*i +: 32] |
| req_active | input | 4 | Lane i takes part in the load |
| mem_req_valid | output | 1 | Line fetch requested |
| mem_req_ready | input | 1 | Cache port takes the fetch this cycle |
| mem_req_line | output | 26 | Line address (byte address bits [31:6]) |
| mem_rsp_valid | input | 1 | Line data present, one cycle after the accepted fetch |
| mem_rsp_data | input | 512 | Line data, word w in bits [32*w +: 32] |
| done | output | 1 | One-cycle quad completion pulse |
| res_data | output | 128 | Word for lane i in bits [32*i +: 32] |
| res_mask | output | 4 | Lane i data valid |
| res_misalign | output | 4 | Lane i address was not word aligned |

## Verification
The bench targets quads in which lanes repeat a line out of order, for example lanes 0 and 3 sharing a line while lane 1 uses another. A merger that only compares neighbouring lanes, or that skips lanes while clearing served lanes, would issue an extra fetch or misorder the line requests. Word indices 0 and 15 are used to catch an off-by-one in the word select. Misaligned and inactive lanes are mixed with active ones: a design that fetched for them, or wrote a stale word into them, would show a wrong request count or non-zero data. Periods where the cache port withholds ready check that a request is held steady and that the one-cycle response pairing is not lost, which would otherwise steer the wrong line into a lane.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_BUSY = 2'd1,
      QS_DONE = 2'd2
   } qlm_state_t;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/qlm_lane_split.sv
module qlm_lane_split #(
   parameter int LANES   = 4,
   parameter int ADDR_W  = 32,
   parameter int OFF_W   = 6,
   parameter int ALIGN_W = 2,
   localparam int TAG_W  = ADDR_W - OFF_W,
   localparam int WIDX_W = (OFF_W - ALIGN_W) > 0 ? (OFF_W - ALIGN_W) : 1
) (
   input  logic [LANES*ADDR_W-1:0] addr,
   output logic [LANES*TAG_W-1:0]  tag,
   output logic [LANES*WIDX_W-1:0] widx,
   output logic [LANES-1:0]        aligned
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ADDR_W-1:0] a;
      assign a = addr[i*ADDR_W +: ADDR_W];
      assign tag[i*TAG_W +: TAG_W] = a[ADDR_W-1:OFF_W];
      assign widx[i*WIDX_W +: WIDX_W] = a[ALIGN_W +: WIDX_W];
      if (ALIGN_W == 0) begin : g_byte
         assign aligned[i] = 1'b1;
      end else begin : g_word
         assign aligned[i] = (a[ALIGN_W-1:0] == '0);
      end
   end

endmodule

// File: rtl/qlm_lead_pick.sv
module qlm_lead_pick #(
   parameter int LANES = 4,
   parameter int TAG_W = 26
) (
   input  logic [LANES-1:0]       pend,
   input  logic [LANES*TAG_W-1:0] tags,
   output logic                   any,
   output logic [TAG_W-1:0]       lead_tag,
   output logic [LANES-1:0]       match
);

   always_comb begin
      lead_tag = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pend[i]) lead_tag = tags[i*TAG_W +: TAG_W];
      end
   end

   assign any = |pend;

   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      assign match[i] = pend[i] && (tags[i*TAG_W +: TAG_W] == lead_tag);
   end

endmodule

// File: rtl/qlm_word_steer.sv
module qlm_word_steer #(
   parameter int LANES  = 4,
   parameter int WORD_W = 32,
   parameter int WORDS  = 16,
   parameter int WIDX_W = 4,
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic [LINE_W-1:0]       line,
   input  logic [LANES*WIDX_W-1:0] widx,
   output logic [LANES*WORD_W-1:0] word
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [WIDX_W-1:0] k;
      assign k = widx[i*WIDX_W +: WIDX_W];
      assign word[i*WORD_W +: WORD_W] = line[k*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/quad_line_merger.sv
module quad_line_merger
   import qlm_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int WORD_BYTES = 4,
   localparam int OFF_W   = $clog2(LINE_BYTES),
   localparam int ALIGN_W = $clog2(WORD_BYTES),
   localparam int WORD_W  = 8 * WORD_BYTES,
   localparam int WORDS   = LINE_BYTES / WORD_BYTES,
   localparam int WIDX_W  = (OFF_W - ALIGN_W) > 0 ? (OFF_W - ALIGN_W) : 1,
   localparam int TAG_W   = ADDR_W - OFF_W,
   localparam int LINE_W  = 8 * LINE_BYTES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]        req_active,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [TAG_W-1:0]        mem_req_line,
   input  logic                    mem_rsp_valid,
   input  logic [LINE_W-1:0]       mem_rsp_data,
   output logic                    done,
   output logic [LANES*WORD_W-1:0] res_data,
   output logic [LANES-1:0]        res_mask,
   output logic [LANES-1:0]        res_misalign
);

   if (!is_pow2(LINE_BYTES)) begin : g_chk_line
      $error("LINE_BYTES must be a power of two");
   end
   if (!is_pow2(WORD_BYTES) || WORD_BYTES >= LINE_BYTES) begin : g_chk_word
      $error("WORD_BYTES must be a power of two below LINE_BYTES");
   end
   if (LANES < 1 || ADDR_W <= OFF_W) begin : g_chk_dims
      $error("LANES and ADDR_W out of range");
   end

   qlm_state_t st;
   logic [LANES*TAG_W-1:0]  tag_in, tags_q;
   logic [LANES*WIDX_W-1:0] widx_in, widx_q;
   logic [LANES-1:0]        aligned_in;
   logic [LANES-1:0]        pend_q, infl_mask_q, mask_q, mis_q;
   logic                    infl_v_q;
   logic [LANES*WORD_W-1:0] data_q, steer_word, steer_bits;
   logic                    any_pend;
   logic [TAG_W-1:0]        lead_tag;
   logic [LANES-1:0]        match;
   logic                    issue, take_rsp, finish;

   qlm_lane_split #(
      .LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_W(ALIGN_W)
   ) u_split (
      .addr(req_addr), .tag(tag_in), .widx(widx_in), .aligned(aligned_in)
   );

   qlm_lead_pick #(
      .LANES(LANES), .TAG_W(TAG_W)
   ) u_pick (
      .pend(pend_q), .tags(tags_q), .any(any_pend), .lead_tag(lead_tag), .match(match)
   );

   qlm_word_steer #(
      .LANES(LANES), .WORD_W(WORD_W), .WORDS(WORDS), .WIDX_W(WIDX_W)
   ) u_steer (
      .line(mem_rsp_data), .widx(widx_q), .word(steer_word)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_expand
      assign steer_bits[i*WORD_W +: WORD_W] = {WORD_W{infl_mask_q[i]}};
   end

   assign take_rsp      = infl_v_q && mem_rsp_valid;
   assign mem_req_valid = (st == QS_BUSY) && any_pend && (!infl_v_q || mem_rsp_valid);
   assign mem_req_line  = lead_tag;
   assign issue         = mem_req_valid && mem_req_ready;
   assign finish        = (st == QS_BUSY) && !any_pend && (!infl_v_q || mem_rsp_valid);

   assign req_ready    = (st == QS_IDLE);
   assign done         = (st == QS_DONE);
   assign res_data     = data_q;
   assign res_mask     = mask_q;
   assign res_misalign = mis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= QS_IDLE;
         tags_q      <= '0;
         widx_q      <= '0;
         pend_q      <= '0;
         infl_v_q    <= 1'b0;
         infl_mask_q <= '0;
         mask_q      <= '0;
         mis_q       <= '0;
         data_q      <= '0;
      end else begin
         case (st)
            QS_IDLE: begin
               if (req_valid) begin
                  st       <= QS_BUSY;
                  tags_q   <= tag_in;
                  widx_q   <= widx_in;
                  pend_q   <= req_active & aligned_in;
                  mis_q    <= req_active & ~aligned_in;
                  mask_q   <= '0;
                  data_q   <= '0;
                  infl_v_q <= 1'b0;
               end
            end
            QS_BUSY: begin
               if (issue) begin
                  pend_q      <= pend_q & ~match;
                  infl_mask_q <= match;
               end
               infl_v_q <= issue || (infl_v_q && !mem_rsp_valid);
               if (take_rsp) begin
                  mask_q <= mask_q | infl_mask_q;
                  data_q <= (data_q & ~steer_bits) | (steer_word & steer_bits);
               end
               if (finish) st <= QS_DONE;
            end
            QS_DONE: st <= QS_IDLE;
            default: st <= QS_IDLE;
         endcase
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R8
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);                     // R8
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line))); // R9
   AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);                                // R2
   AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> infl_v_q);                                  // R2
   AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((res_mask & res_misalign) == '0));                  // R5
   AST_FETCH_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (infl_mask_q != '0));                               // R3

endmodule

// File: tb/tb_quad_line_merger.sv
module tb_quad_line_merger;

   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [127:0]  req_addr = '0;
   logic [3:0]    req_active = '0;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b1;
   logic [25:0]   mem_req_line;
   logic          mem_rsp_valid = 1'b0;
   logic [511:0]  mem_rsp_data = '0;
   logic          done;
   logic [127:0]  res_data;
   logic [3:0]    res_mask;
   logic [3:0]    res_misalign;

   int checks = 0;
   int errors = 0;
   int n_issued = 0;
   logic [25:0] issued [8];
   bit stall_mode = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_line_merger dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_active(req_active),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_line(mem_req_line),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .res_data(res_data), .res_mask(res_mask),
      .res_misalign(res_misalign)
   );

   function automatic logic [31:0] mem_word(input logic [25:0] t, input int w);
      return (32'(t) * 32'h9E37_79B1) ^ (32'(w) * 32'h0100_0193) ^ 32'h1234_5678;
   endfunction

   function automatic logic [511:0] line_of(input logic [25:0] t);
      logic [511:0] l;
      for (int w = 0; w < 16; w++) l[w*32 +: 32] = mem_word(t, w);
      return l;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one-cycle line memory; also records issued lines and checks request hold
   initial begin : mem_model
      bit pend = 0;
      bit hold = 0;
      logic [25:0] pend_tag = '0;
      logic [25:0] hold_tag = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = pend;
         mem_rsp_data  = pend ? line_of(pend_tag) : '0;
         mem_req_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
         #1;
         if (hold) chk(mem_req_valid && mem_req_line == hold_tag, "R9 held request",
                       {101'b0, mem_req_valid, mem_req_line}, {101'b0, 1'b1, hold_tag});
         pend     = mem_req_valid && mem_req_ready;
         pend_tag = mem_req_line;
         hold     = mem_req_valid && !mem_req_ready;
         hold_tag = mem_req_line;
         if (pend) begin
            if (n_issued < 8) issued[n_issued] = mem_req_line;
            n_issued++;
         end
      end
   end

   task automatic run_quad(input logic [127:0] a, input logic [3:0] act, input bit lat_chk);
      logic [25:0]  uniq [4];
      int           nu = 0;
      logic [127:0] exp_data = '0;
      logic [3:0]   exp_mask = '0;
      logic [3:0]   exp_mis = '0;
      int           edges = 0;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] ai = a[i*32 +: 32];
         if (act[i]) begin
            if (ai[1:0] != 2'b00) exp_mis[i] = 1'b1;
            else begin
               bit seen = 0;
               for (int j = 0; j < nu; j++) if (uniq[j] == ai[31:6]) seen = 1;
               if (!seen) begin uniq[nu] = ai[31:6]; nu++; end
               exp_mask[i] = 1'b1;
               exp_data[i*32 +: 32] = mem_word(ai[31:6], int'(ai[5:2]));
            end
         end
      end
      @(negedge clk);
      n_issued = 0;
      chk(req_ready == 1'b1, "R8 ready before quad", {127'b0, req_ready}, 128'd1);
      req_valid = 1'b1; req_addr = a; req_active = act;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_addr = {4{32'hDEAD_BEEF}}; req_active = 4'hF;
      chk(req_ready == 1'b0, "R8 busy after accept", {127'b0, req_ready}, 128'd0);
      while (!done && edges < 1000) begin
         @(negedge clk);
         edges++;
      end
      chk(res_data == exp_data, "R4 lane data", res_data, exp_data);
      chk(res_mask == exp_mask, "R4 R6 valid mask", {124'b0, res_mask}, {124'b0, exp_mask});
      chk(res_misalign == exp_mis, "R5 misalign mask", {124'b0, res_misalign}, {124'b0, exp_mis});
      chk(n_issued == nu, "R2 line request count", 128'(n_issued), 128'(nu));
      for (int j = 0; j < nu && j < n_issued; j++)
         chk(issued[j] == uniq[j], "R3 request order", {102'b0, issued[j]}, {102'b0, uniq[j]});
      if (lat_chk)
         chk(edges == nu + 1, (nu == 0) ? "R10 empty latency" : "R7 latency", 128'(edges), 128'(nu + 1));
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", {127'b0, done}, 128'd0);
   endtask

   function automatic logic [31:0] mk(input logic [25:0] t, input int widx, input int b);
      return {t, 4'(widx), 2'(b)};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1 reset state",
          {125'b0, req_ready, done, mem_req_valid}, 128'b100);
      rst_n = 1'b1;
      @(negedge clk);
      // all lanes in one line, extreme word indices
      run_quad({mk(26'h100, 15, 0), mk(26'h100, 0, 0), mk(26'h100, 7, 0), mk(26'h100, 3, 0)}, 4'hF, 1);
      // four lines, descending by lane
      run_quad({mk(26'h10, 1, 0), mk(26'h20, 2, 0), mk(26'h30, 3, 0), mk(26'h40, 4, 0)}, 4'hF, 1);
      // lanes 0 and 3 share, lanes 1 and 2 share
      run_quad({mk(26'h55, 9, 0), mk(26'h77, 8, 0), mk(26'h77, 2, 0), mk(26'h55, 1, 0)}, 4'hF, 1);
      // empty quad
      run_quad({mk(26'h1, 1, 0), mk(26'h2, 2, 0), mk(26'h3, 3, 0), mk(26'h4, 4, 0)}, 4'h0, 1);
      // misaligned lanes, one inactive
      run_quad({mk(26'h9, 5, 2), mk(26'h9, 6, 0), mk(26'h8, 1, 1), mk(26'h8, 0, 0)}, 4'b1011, 1);
      // only lane 3
      run_quad({mk(26'h3FF_FFFF, 15, 0), mk(26'h0, 0, 0), mk(26'h0, 0, 0), mk(26'h0, 0, 0)}, 4'b1000, 1);
      // random, cache always ready
      for (int n = 0; n < 300; n++) begin
         logic [127:0] a;
         logic [25:0] base = 26'($urandom);
         for (int i = 0; i < 4; i++)
            a[i*32 +: 32] = mk(base + 26'($urandom % 3), int'($urandom % 16),
                               (($urandom % 8) == 0) ? int'($urandom % 4) : 0);
         run_quad(a, 4'($urandom), 1);
      end
      // random, cache port stalls
      stall_mode = 1;
      for (int n = 0; n < 200; n++) begin
         logic [127:0] a;
         logic [25:0] base = 26'($urandom);
         for (int i = 0; i < 4; i++)
            a[i*32 +: 32] = mk(base + 26'($urandom % 4), int'($urandom % 16),
                               (($urandom % 8) == 0) ? int'($urandom % 4) : 0);
         run_quad(a, 4'($urandom), 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule